// File: doc/BRIEF.md
# Dual-Clock FIFO with Hysteretic Status Flags

This block moves data words from one clock domain into another through a small dual-port register array. Each side keeps its own binary pointer. The pointer is turned into Gray code and passed through a chain of synchroniser flops into the other domain. The opposite side uses it there to judge how full the queue is. Every status flag is a register in its own domain. The write side raises full, almost-full and a write-error flag. The read side raises empty, almost-empty and a read-error flag.

The two "almost" flags are warnings with a dead band. A flag sets when the relevant level (stored words for the read side, free slots for the write side) drops to its threshold or below. It clears only once the level rises at least two above the threshold. In between it keeps its old value. A write refused because the queue is full, or a read refused because it is empty, leaves the pointer untouched. Such a refused request also raises that side's error flag for as long as the request is held against the blocking condition. Read data comes out of a register one read clock after an accepted read.

Top module: `xclk_fifo`

## Requirements
- R1: After both resets, empty and almost_empty read 1, and full, almost_full, wr_err and rd_err read 0.
- R2: Words accepted on the write side appear on rd_data in the order they were written, one read clock after each accepted read (rd_en high while empty is 0).
- R3: After the first write into an empty queue, empty stays 1 at the first read-clock edge that follows, and falls within a few read clocks once the write pointer has crossed the synchroniser.
- R4: With DEPTH words stored, full reads 1, and further writes change nothing: draining the queue returns exactly the DEPTH accepted words and no word offered while full.
- R5: A write request at a write-clock edge where full is 1 sets wr_err at that edge. wr_err returns to 0 at the first edge where wr_en or full was 0.
- R6: A read request at a read-clock edge where empty is 1 sets rd_err at that edge and leaves rd_data and the read pointer unchanged. rd_err returns to 0 at the first edge where rd_en or empty was 0.
- R7: almost_full sets once the free-slot count is at or below AF_LEVEL. It stays 0 while the free count sits at AF_LEVEL+1 having arrived from above.
- R8: Once set, almost_full stays 1 while free slots equal AF_LEVEL+1, and clears only when free slots exceed AF_LEVEL+1.
- R9: almost_empty is 1 while the stored count is at or below AE_LEVEL, holds its value when the count equals AE_LEVEL+1, and clears only when the count exceeds AE_LEVEL+1. Whenever empty is 1, almost_empty is also 1.
- R10: After a read from a full queue, full stays 1 at the first write-clock edge that follows, and falls within a few write clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot |
| almost_full | output | 1 | Free slots at or below threshold (with dead band) |
| wr_err | output | 1 | Write requested while full |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| empty | output | 1 | No stored word |
| almost_empty | output | 1 | Stored words at or below threshold (with dead band) |
| rd_err | output | 1 | Read requested while empty |

## Verification
The hardest states to reach are the dead bands of the two almost flags. A level of exactly threshold+1 holds the flag's old value, so a correct check needs the same level approached once from above and once from below. The bench walks the stored count up one word at a time, then down one word at a time. After each step it waits long enough for the pointer to cross the synchroniser before sampling. That way the flag settles on the level and is not caught in transit. The synchroniser latency itself is tested from the ports by sampling the flag at the very next edge after the pointer moves, where it must not yet have changed.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside
  import xfifo_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int AF_LEVEL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_s,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              we,
  output logic              full,
  output logic              almost_full,
  output logic              wr_err
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);
  localparam logic [PW-1:0] LO_V    = PW'(AF_LEVEL);
  localparam logic [PW-1:0] HI_V    = PW'(AF_LEVEL + 1);

  logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, free_nx, full_pat;

  assign we       = wr_en & ~full;
  assign waddr    = wbin[ADDR_W-1:0];
  assign wbin_nx  = wbin + PW'(we);
  assign wgray_nx = PW'(bin2gray(32'(wbin_nx)));
  assign rbin_s   = PW'(gray2bin(32'(rgray_s)));
  assign free_nx  = DEPTH_V - (wbin_nx - rbin_s);
  assign full_pat = {~rgray_s[ADDR_W:ADDR_W-1], rgray_s[ADDR_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      wr_err      <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full   <= (wgray_nx == full_pat);
      wr_err <= wr_en & full;
      if (free_nx <= LO_V)     almost_full <= 1'b1;
      else if (free_nx > HI_V) almost_full <= 1'b0;
    end
  end

  p_full_af_r7: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> $stable(wbin));
  p_werr_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_err) |-> $past(full));
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
  import xfifo_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int AE_LEVEL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_s,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              re,
  output logic              empty,
  output logic              almost_empty,
  output logic              rd_err
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] LO_V = PW'(AE_LEVEL);
  localparam logic [PW-1:0] HI_V = PW'(AE_LEVEL + 1);

  logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, used_nx;

  assign re       = rd_en & ~empty;
  assign raddr    = rbin[ADDR_W-1:0];
  assign rbin_nx  = rbin + PW'(re);
  assign rgray_nx = PW'(bin2gray(32'(rbin_nx)));
  assign wbin_s   = PW'(gray2bin(32'(wgray_s)));
  assign used_nx  = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
      rd_err       <= 1'b0;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rgray_nx;
      empty  <= (rgray_nx == wgray_s);
      rd_err <= rd_en & empty;
      if (used_nx <= LO_V)     almost_empty <= 1'b1;
      else if (used_nx > HI_V) almost_empty <= 1'b0;
    end
  end

  p_empty_ae_r9: assert property (@(posedge clk) disable iff (rst)
    empty |-> almost_empty);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rbin));
  p_rerr_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_err) |-> $past(empty));
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int AE_LEVEL    = 3,
  parameter int AF_LEVEL    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  output logic              wr_err,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              rd_err
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we, re;

  xfifo_wside #(.ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wside (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rgray_s(rgray_s),
    .wgray(wgray), .waddr(waddr), .we(we), .full(full),
    .almost_full(almost_full), .wr_err(wr_err)
  );

  xfifo_rside #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rside (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wgray_s(wgray_s),
    .rgray(rgray), .raddr(raddr), .re(re), .empty(empty),
    .almost_empty(almost_empty), .rd_err(rd_err)
  );

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  xfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
  localparam int DW = 8;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, almost_full, wr_err, empty, almost_empty, rd_err;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 wr_clk = ~wr_clk;   // 125 MHz
  always #5 rd_clk = ~rd_clk;

  xclk_fifo u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .almost_full(almost_full), .wr_err(wr_err),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty), .rd_err(rd_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge wr_clk); wr_en = 1; wr_data = v;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic pop(output logic [DW-1:0] v);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0; v = rd_data;
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic t_reset();
    chk(empty == 1, "R1 empty", empty, 1);
    chk(almost_empty == 1, "R1 almost_empty", almost_empty, 1);
    chk(full == 0, "R1 full", full, 0);
    chk(almost_full == 0, "R1 almost_full", almost_full, 0);
    chk(wr_err == 0, "R1 wr_err", wr_err, 0);
    chk(rd_err == 0, "R1 rd_err", rd_err, 0);
  endtask

  task automatic t_low_side();
    logic [DW-1:0] v;
    int n;
    push(8'hA0);
    @(posedge rd_clk); #1;
    chk(empty == 1, "R3 empty held at next edge", empty, 1);
    n = 0;
    while (empty && n < 10) begin @(posedge rd_clk); #1; n++; end
    chk(empty == 0 && n <= 8, "R3 empty falls after sync", n, 8);
    for (int i = 1; i < 4; i++) push(8'hA0 + 8'(i));
    settle();
    chk(almost_empty == 1, "R9 count=AE+1 from below holds 1", almost_empty, 1);
    push(8'hA4);
    settle();
    chk(almost_empty == 0, "R9 count>AE+1 clears", almost_empty, 0);
    pop(v); chk(v == 8'hA0, "R2 order", v, 8'hA0);
    settle();
    chk(almost_empty == 0, "R9 count=AE+1 from above holds 0", almost_empty, 0);
    pop(v); chk(v == 8'hA1, "R2 order", v, 8'hA1);
    settle();
    chk(almost_empty == 1, "R9 count=AE sets", almost_empty, 1);
    for (int i = 2; i < 5; i++) begin
      pop(v); chk(v == 8'hA0 + 8'(i), "R2 order", v, 8'hA0 + i);
    end
    settle();
    chk(empty == 1, "R2 empty after drain", empty, 1);
  endtask

  task automatic t_high_side();
    logic [DW-1:0] v;
    int n;
    for (int i = 0; i < 12; i++) push(8'hB0 + 8'(i));
    settle();
    chk(almost_full == 0, "R7 free=AF+1 from above stays 0", almost_full, 0);
    push(8'hBC);
    settle();
    chk(almost_full == 1, "R7 free=AF sets", almost_full, 1);
    pop(v); chk(v == 8'hB0, "R2 order", v, 8'hB0);
    settle();
    chk(almost_full == 1, "R8 free=AF+1 holds 1", almost_full, 1);
    pop(v); chk(v == 8'hB1, "R2 order", v, 8'hB1);
    settle();
    chk(almost_full == 0, "R8 free>AF+1 clears", almost_full, 0);
    for (int i = 13; i < 18; i++) push(8'hB0 + 8'(i));
    settle();
    chk(full == 1, "R4 full at depth", full, 1);
    // R5: refused writes raise wr_err
    @(negedge wr_clk); wr_en = 1; wr_data = 8'hEE;
    @(negedge wr_clk);
    chk(wr_err == 1, "R5 wr_err set", wr_err, 1);
    @(negedge wr_clk);
    chk(wr_err == 1, "R5 wr_err held", wr_err, 1);
    wr_en = 0;
    @(negedge wr_clk);
    chk(wr_err == 0, "R5 wr_err clears", wr_err, 0);
    // R10: full release latency
    pop(v); chk(v == 8'hB2, "R2 order", v, 8'hB2);
    @(posedge wr_clk); #1;
    chk(full == 1, "R10 full held at next edge", full, 1);
    n = 0;
    while (full && n < 10) begin @(posedge wr_clk); #1; n++; end
    chk(full == 0 && n <= 8, "R10 full falls after sync", n, 8);
    for (int i = 3; i < 18; i++) begin
      pop(v); chk(v == 8'hB0 + 8'(i), "R4 drain without refused word", v, 8'hB0 + i);
    end
    settle();
    chk(empty == 1, "R4 nothing extra stored", empty, 1);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] keep;
    keep = rd_data;
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk);
    chk(rd_err == 1, "R6 rd_err set", rd_err, 1);
    chk(rd_data == keep, "R6 rd_data unchanged", rd_data, keep);
    rd_en = 0;
    @(negedge rd_clk);
    chk(rd_err == 0, "R6 rd_err clears", rd_err, 0);
    push(8'h5A);
    settle();
    begin
      logic [DW-1:0] v;
      pop(v); chk(v == 8'h5A, "R6 read pointer not advanced", v, 8'h5A);
    end
  endtask

  initial begin
    repeat (4) @(negedge wr_clk);
    wr_rst = 0;
    repeat (4) @(negedge rd_clk);
    rd_rst = 0;
    settle();
    t_reset();
    t_low_side();
    t_high_side();
    t_underflow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule